// File: doc/BRIEF.md
# Display Command List Register Front End

This block is the host-facing register set of a display command processor. Software writes the first and the last byte address of a command list held in memory, and the block passes them to the processor. A write to the start register only arms a pending start. The next write to the end register commits that start into the current pointer. Every end write raises a one-cycle kick that tells the processor to fetch up to the new end. An end write with no pending start extends the list already running, so fetching continues from wherever the processor has advanced the current pointer. Every address the block stores is forced to 8-byte alignment.

The block also holds three mode flags: external-bus source, freeze and flush. Each flag has its own clear bit and set bit in a status write. A free-running cycle counter advances by a fixed step on every read of the clock register and returns the advanced value. While freeze is set, that read returns zero and the counter holds. A status write can also zero the counter.

Reads have one cycle of latency. `reg_rvalid` rises in the cycle after `reg_rd` is sampled, and `reg_rdata` carries the value in that same cycle.

Top module: `disp_cmd_regs`

## Requirements
- R1: Synchronous active-low reset clears start, end, current, the pending-start flag, all three mode flags, the counter, `kick` and `reg_rvalid`.
- R2: A write to offset 0x00 while no start is pending stores the data with bits 2:0 cleared and sets the pending flag. While a start is pending, such a write changes nothing.
- R3: A write to offset 0x04 while a start is pending does all of the following: clears the pending flag, copies start into current, and stores the data with bits 2:0 cleared as the end.
- R4: A write to offset 0x04 with no start pending updates only the aligned end. Current keeps its value.
- R5: `kick` is high for exactly the one cycle after each write to offset 0x04, and never after any other access.
- R6: Current is loaded from `adv_addr`, with bits 2:0 cleared, in the cycle after `adv_en`. A committing end write (R3) in the same cycle takes priority over `adv_en`.
- R7: A status write (offset 0x0C) acts on these bits:
  - bit 0 clears the external-bus flag and bit 1 sets it;
  - bit 2 clears freeze and bit 3 sets it;
  - bit 4 clears flush and bit 5 sets it;
  - when both bits of a pair are 1, the flag ends up set.
- R8: A read of offset 0x10 while freeze is clear adds 13 to the counter and returns the new value. While freeze is set, that read returns 0 and the counter is left unchanged. A status write with bit 9 set zeroes the counter.
- R9: Reads return start (0x00), end (0x04), current (0x08) and status (0x0C), and return 0 for any unmapped offset. The status read places external-bus at bit 0, freeze at bit 1, flush at bit 2 and pending-start at bit 3. Read data and `reg_rvalid` appear one cycle after `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid together with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| adv_en | input | 1 | Processor advances the current pointer |
| adv_addr | input | 32 | New current pointer from the processor |
| kick | output | 1 | One-cycle request to fetch up to the end |
| list_start | output | 32 | Committed or pending start address |
| list_end | output | 32 | End address |
| list_cur | output | 32 | Current fetch pointer |
| start_pending | output | 1 | A start has been written and awaits an end |
| xbus_mode | output | 1 | External-bus source flag |
| frozen | output | 1 | Freeze flag |
| flushing | output | 1 | Flush flag |

## Verification
The bench targets the pending-start handshake at these points:
- A second start write while a start is pending. A design that overwrote the start would report the later address.
- An end write with no start pending. A design that always copied start into current would rewind the processor.
- A committing end write that coincides with `adv_en`. A design with the wrong priority would keep the processor's pointer instead of the new list head.

The bench also covers the clock register. It reads the register while frozen, where a wrong design would return the stale count or keep counting. It zeroes the counter and checks that the next read returns one step.

Finally, it writes a status word with both bits of a pair set, which exposes a clear-wins ordering. It checks the kick width, to catch a level where a pulse is required, and a mid-sequence reset.

// File: rtl/dcb_pkg.sv
// Shared offsets, status command bit positions and flag indices for the
// display command list register front end.
package dcb_pkg;
    localparam int OFS_W  = 5;
    localparam int NFLAG  = 3;

    localparam logic [OFS_W-1:0] OFS_START = 5'h00;
    localparam logic [OFS_W-1:0] OFS_END   = 5'h04;
    localparam logic [OFS_W-1:0] OFS_CUR   = 5'h08;
    localparam logic [OFS_W-1:0] OFS_STAT  = 5'h0C;
    localparam logic [OFS_W-1:0] OFS_CLK   = 5'h10;

    // Flag indices: 0 external bus, 1 freeze, 2 flush (also the read order).
    localparam int FLG_XBUS   = 0;
    localparam int FLG_FREEZE = 1;
    localparam int FLG_FLUSH  = 2;

    // Status-write command bit positions per flag (clear, set).
    localparam int FLAG_CLR_POS [NFLAG] = '{0, 2, 4};
    localparam int FLAG_SET_POS [NFLAG] = '{1, 3, 5};
    localparam int CNT_ZERO_POS = 9;
endpackage

// File: rtl/dcb_ptr_ctrl.sv
// Pointer control: holds start, end and current, runs the pending-start
// handshake and raises the one-cycle kick. Assumes start and end write
// strobes are never active together (they come from distinct offsets).
module dcb_ptr_ctrl #(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_BITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic              wr_end,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              adv_en,
    input  logic [ADDR_W-1:0] adv_addr,
    output logic [ADDR_W-1:0] start_q,
    output logic [ADDR_W-1:0] end_q,
    output logic [ADDR_W-1:0] cur_q,
    output logic              pend_q,
    output logic              kick_q
);
    localparam logic [ADDR_W-1:0] LOW_ONES   = ADDR_W'((1 << ALIGN_BITS) - 1);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~LOW_ONES;

    logic [ADDR_W-1:0] wdata_al;
    logic [ADDR_W-1:0] adv_al;

    // Force incoming addresses to the alignment boundary.
    always_comb begin
        wdata_al = wdata & ALIGN_MASK;
        adv_al   = adv_addr & ALIGN_MASK;
    end

    // Start/end/current registers with the pending-start handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= '0;
            cur_q   <= '0;
            pend_q  <= 1'b0;
            kick_q  <= 1'b0;
        end else begin
            kick_q <= 1'b0;
            if (wr_start && !pend_q) begin
                start_q <= wdata_al;
                pend_q  <= 1'b1;
            end
            if (wr_end) begin
                end_q  <= wdata_al;
                kick_q <= 1'b1;
                if (pend_q) begin
                    pend_q <= 1'b0;
                    cur_q  <= start_q;
                end else if (adv_en) begin
                    cur_q <= adv_al;
                end
            end else if (adv_en) begin
                cur_q <= adv_al;
            end
        end
    end
endmodule

// File: rtl/dcb_flags.sv
// Mode flags with a clear bit and a set bit each in the status write.
// Assumes set takes precedence when both bits of a pair are written.
module dcb_flags
    import dcb_pkg::*;
#(
    parameter int CMD_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stat,
    input  logic [CMD_W-1:0] cmd,
    output logic [NFLAG-1:0] flags_q
);
    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        // One flag: apply clear, then set, on a status write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags_q[g] <= 1'b0;
            end else if (wr_stat) begin
                if (cmd[FLAG_SET_POS[g]]) begin
                    flags_q[g] <= 1'b1;
                end else if (cmd[FLAG_CLR_POS[g]]) begin
                    flags_q[g] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/dcb_clock_ctr.sv
// Cycle counter advanced by a fixed step per read. The caller gates the
// bump with freeze; a zero request wins over a bump in the same cycle.
module dcb_clock_ctr #(
    parameter int CNT_W = 32,
    parameter int STEP  = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    input  logic             zero,
    output logic [CNT_W-1:0] bumped
);
    logic [CNT_W-1:0] cnt_q;

    // Value the counter takes on a bump, also returned by the read.
    always_comb bumped = cnt_q + CNT_W'(STEP);

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (zero) begin
            cnt_q <= '0;
        end else if (bump) begin
            cnt_q <= bumped;
        end
    end
endmodule

// File: rtl/disp_cmd_regs.sv
// Register front end of a display command processor: decodes the host
// port, instantiates pointer control, mode flags and the clock counter,
// and returns registered read data one cycle after a read strobe.
// Assumes ADDR_W and CNT_W do not exceed DATA_W.
module disp_cmd_regs
    import dcb_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 32,
    parameter int ALIGN_BITS = 3,
    parameter int CLK_STEP   = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [OFS_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rvalid,
    input  logic              adv_en,
    input  logic [ADDR_W-1:0] adv_addr,
    output logic              kick,
    output logic [ADDR_W-1:0] list_start,
    output logic [ADDR_W-1:0] list_end,
    output logic [ADDR_W-1:0] list_cur,
    output logic              start_pending,
    output logic              xbus_mode,
    output logic              frozen,
    output logic              flushing
);
    localparam int CMD_W = CNT_ZERO_POS + 1;

    logic             wr_start, wr_end, wr_stat, rd_clk;
    logic [NFLAG-1:0] flags;
    logic [CNT_W-1:0] clk_bumped;

    // Decode write and read strobes by offset.
    always_comb begin
        wr_start = reg_wr && (reg_addr == OFS_START);
        wr_end   = reg_wr && (reg_addr == OFS_END);
        wr_stat  = reg_wr && (reg_addr == OFS_STAT);
        rd_clk   = reg_rd && (reg_addr == OFS_CLK);
    end

    dcb_ptr_ctrl #(
        .ADDR_W    (ADDR_W),
        .ALIGN_BITS(ALIGN_BITS)
    ) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_start(wr_start),
        .wr_end  (wr_end),
        .wdata   (reg_wdata[ADDR_W-1:0]),
        .adv_en  (adv_en),
        .adv_addr(adv_addr),
        .start_q (list_start),
        .end_q   (list_end),
        .cur_q   (list_cur),
        .pend_q  (start_pending),
        .kick_q  (kick)
    );

    dcb_flags #(
        .CMD_W(CMD_W)
    ) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stat(wr_stat),
        .cmd    (reg_wdata[CMD_W-1:0]),
        .flags_q(flags)
    );

    dcb_clock_ctr #(
        .CNT_W(CNT_W),
        .STEP (CLK_STEP)
    ) u_clk (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (rd_clk && !flags[FLG_FREEZE]),
        .zero  (wr_stat && reg_wdata[CNT_ZERO_POS]),
        .bumped(clk_bumped)
    );

    // Flag outputs.
    always_comb begin
        xbus_mode = flags[FLG_XBUS];
        frozen    = flags[FLG_FREEZE];
        flushing  = flags[FLG_FLUSH];
    end

    // Registered read mux with one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= reg_rd;
            if (reg_rd) begin
                case (reg_addr)
                    OFS_START: reg_rdata <= DATA_W'(list_start);
                    OFS_END:   reg_rdata <= DATA_W'(list_end);
                    OFS_CUR:   reg_rdata <= DATA_W'(list_cur);
                    OFS_STAT:  reg_rdata <= DATA_W'({start_pending, flags});
                    OFS_CLK:   reg_rdata <= flags[FLG_FREEZE] ? '0 : DATA_W'(clk_bumped);
                    default:   reg_rdata <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/dcb_checker.sv
// Protocol checker for disp_cmd_regs, attached by bind below.
module dcb_checker
    import dcb_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 32,
    parameter int ALIGN_BITS = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [OFS_W-1:0]  reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              reg_rvalid,
    input logic              adv_en,
    input logic              kick,
    input logic [ADDR_W-1:0] list_start,
    input logic [ADDR_W-1:0] list_end,
    input logic [ADDR_W-1:0] list_cur,
    input logic              start_pending,
    input logic              frozen
);
    localparam logic [ADDR_W-1:0] LOW_ONES = ADDR_W'((1 << ALIGN_BITS) - 1);

    logic wr_s, wr_e, rd_c;
    always_comb begin
        wr_s = reg_wr && (reg_addr == OFS_START);
        wr_e = reg_wr && (reg_addr == OFS_END);
        rd_c = reg_rd && (reg_addr == OFS_CLK);
    end

    a_r2_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_s && start_pending) |=> ($stable(list_start) && start_pending));

    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        ((list_start & LOW_ONES) == '0) && ((list_end & LOW_ONES) == '0));

    a_r3_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_e && start_pending) |=> (!start_pending && list_cur == $past(list_start)));

    a_r4_cur_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_e && !start_pending && !adv_en) |=> $stable(list_cur));

    a_r5_kick_on_end: assert property (@(posedge clk) disable iff (!rst_n)
        wr_e |=> kick);

    a_r5_no_stray_kick: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_e |=> !kick);

    a_r8_frozen_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_c && frozen) |=> (reg_rdata == '0));

    a_r9_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);

    a_r9_no_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !reg_rvalid);
endmodule

bind disp_cmd_regs dcb_checker #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .ALIGN_BITS(ALIGN_BITS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .reg_rdata    (reg_rdata),
    .reg_rvalid   (reg_rvalid),
    .adv_en       (adv_en),
    .kick         (kick),
    .list_start   (list_start),
    .list_end     (list_end),
    .list_cur     (list_cur),
    .start_pending(start_pending),
    .frozen       (frozen)
);

// File: tb/disp_cmd_regs_tb.sv
module disp_cmd_regs_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 26;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic        adv_en = 1'b0;
    logic [31:0] adv_addr = '0;
    logic        kick;
    logic [31:0] list_start, list_end, list_cur;
    logic        start_pending, xbus_mode, frozen, flushing;

    int n_run = 0, n_fail = 0;
    logic        last_kick;
    logic [31:0] rd_val;

    always #(CLK_PERIOD/2) clk = ~clk;

    disp_cmd_regs u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .adv_en(adv_en), .adv_addr(adv_addr),
        .kick(kick), .list_start(list_start), .list_end(list_end),
        .list_cur(list_cur), .start_pending(start_pending),
        .xbus_mode(xbus_mode), .frozen(frozen), .flushing(flushing)
    );

    // Vector: {is_read(1), offset(5), write data(32), expected read(32)}
    localparam logic [69:0] VEC [NVEC] = '{
        {1'b0, 5'h00, 32'h0000_1003, 32'h0},          // R2 arm start
        {1'b1, 5'h00, 32'h0, 32'h0000_1000},          // R2 aligned
        {1'b1, 5'h0C, 32'h0, 32'h0000_0008},          // R9 pending at bit 3
        {1'b0, 5'h00, 32'h0000_2000, 32'h0},          // R2 ignored write
        {1'b1, 5'h00, 32'h0, 32'h0000_1000},          // R2 start kept
        {1'b0, 5'h04, 32'h0000_10FF, 32'h0},          // R3 commit
        {1'b1, 5'h04, 32'h0, 32'h0000_10F8},          // R3 end aligned
        {1'b1, 5'h08, 32'h0, 32'h0000_1000},          // R3 cur = start
        {1'b1, 5'h0C, 32'h0, 32'h0000_0000},          // R3 pending cleared
        {1'b0, 5'h04, 32'h0000_2007, 32'h0},          // R4 extend
        {1'b1, 5'h04, 32'h0, 32'h0000_2000},          // R4 end updated
        {1'b1, 5'h08, 32'h0, 32'h0000_1000},          // R4 cur unchanged
        {1'b0, 5'h0C, 32'h0000_0022, 32'h0},          // R7 set xbus, flush
        {1'b1, 5'h0C, 32'h0, 32'h0000_0005},          // R7
        {1'b0, 5'h0C, 32'h0000_0011, 32'h0},          // R7 clear both
        {1'b1, 5'h0C, 32'h0, 32'h0000_0000},          // R7
        {1'b0, 5'h0C, 32'h0000_0008, 32'h0},          // R7 set freeze
        {1'b1, 5'h0C, 32'h0, 32'h0000_0002},          // R7
        {1'b1, 5'h10, 32'h0, 32'h0000_0000},          // R8 frozen read
        {1'b0, 5'h0C, 32'h0000_0004, 32'h0},          // R7 clear freeze
        {1'b1, 5'h10, 32'h0, 32'h0000_001A},          // R8 13 -> 26, held while frozen
        {1'b0, 5'h0C, 32'h0000_0200, 32'h0},          // R8 zero counter
        {1'b1, 5'h10, 32'h0, 32'h0000_000D},          // R8 one step
        {1'b0, 5'h0C, 32'h0000_000C, 32'h0},          // R7 both freeze bits: set wins
        {1'b1, 5'h0C, 32'h0, 32'h0000_0002},          // R7
        {1'b1, 5'h14, 32'h0, 32'h0000_0000}           // R9 unmapped
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        last_kick = kick;
    endtask

    task automatic do_read(input logic [4:0] a);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        rd_val = reg_rdata;
        check("R9 rvalid", {31'b0, reg_rvalid}, 32'h1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 start", list_start, 32'h0);
        check("R1 end", list_end, 32'h0);
        check("R1 cur", list_cur, 32'h0);
        check("R1 flags", {28'b0, start_pending, flushing, frozen, xbus_mode}, 32'h0);
        check("R1 kick", {31'b0, kick}, 32'h0);
        do_read(5'h0C); check("R9 status after reset", rd_val, 32'h0);
        do_read(5'h10); check("R8 first clock read", rd_val, 32'd13);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][69]) begin
                do_read(VEC[i][68:64]);
                check($sformatf("R9 vector %0d", i), rd_val, VEC[i][31:0]);
            end else begin
                do_write(VEC[i][68:64], VEC[i][63:32]);
            end
        end
        do_write(5'h0C, 32'h0000_0004);

        // R5 kick only on end writes, one cycle wide
        do_write(5'h00, 32'h0000_3000);
        check("R5 no kick on start", {31'b0, last_kick}, 32'h0);
        do_write(5'h04, 32'h0000_3100);
        check("R5 kick after end", {31'b0, last_kick}, 32'h1);
        check("R3 cur from start", list_cur, 32'h0000_3000);
        @(negedge clk);
        check("R5 kick one cycle", {31'b0, kick}, 32'h0);

        // R6 advance, then R4 end write keeps advanced pointer
        @(negedge clk); adv_en = 1'b1; adv_addr = 32'h0000_3013;
        @(negedge clk); adv_en = 1'b0;
        check("R6 advance aligned", list_cur, 32'h0000_3010);
        do_write(5'h04, 32'h0000_3200);
        check("R4 cur kept", list_cur, 32'h0000_3010);
        check("R4 kick", {31'b0, last_kick}, 32'h1);

        // R6 committing end write beats advance
        do_write(5'h00, 32'h0000_4000);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'h04; reg_wdata = 32'h0000_4100;
        adv_en = 1'b1; adv_addr = 32'h0000_5000;
        @(negedge clk);
        reg_wr = 1'b0; adv_en = 1'b0;
        check("R6 commit priority", list_cur, 32'h0000_4000);

        // R1 reset mid-sequence
        do_write(5'h00, 32'h0000_6000);
        do_write(5'h0C, 32'h0000_0022);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        check("R1 start after reset", list_start, 32'h0);
        check("R1 flags after reset", {28'b0, start_pending, flushing, frozen, xbus_mode}, 32'h0);
        do_read(5'h10); check("R1 counter cleared", rd_val, 32'd13);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule